// File: doc/BRIEF.md
# Serial Flash Slave Hold and Write-Protect Front End

This block sits between the four serial pins of an SPI-style flash slave and the chip's internal command layer. A fast system clock oversamples the serial clock, chip select, hold and data-in pins. Incoming bits are gathered into bytes, and outgoing bytes are shifted onto the data-out pin. A hold state machine lets the bus master pause a transfer part-way through. While the transfer is paused, the bit logic is frozen and the data-out pin is released to high impedance. A deselect during a pause resets the serial logic, and the slave stays locked out until the hold pin has been released.

The block also guards program and erase requests. Three block-protect bits from the status register select a protected range of sectors, counted upward from sector 0. A request whose target sector falls inside that range is taken from the requester and dropped, and an error flag pulses. A request outside the range goes on to the command layer, unless the busy input shows that an internal operation is still running. Neither the hold machine nor a deselect has any effect on this request path.

Three valid/ready streams carry the data. On each stream a transfer happens in a cycle where valid and ready are both high.
- **Received bytes (rx).** A byte stays on the outputs until it is accepted. Any byte that completes while the previous one is still waiting is dropped, so the command layer must accept within one byte time.
- **Transmit bytes (tx).** This stream is sampled only at byte boundaries. If no byte is offered, the slave shifts out 0xFF.
- **Requests (req to cmd).** This stream passes straight through, except for rejected requests, which are accepted at once.

Top module: `sfl_front`

## Requirements
- R1: Data-in is sampled on each rising serial-clock edge while the block is selected and not held, MSB first. After the 8th rising edge the byte appears on rx_data_o with rx_valid_o high.
- R2: rx_valid_o and rx_data_o hold steady until rx_ready_o... is seen high, that is, until the cycle where rx_ready_i is high. A byte that completes while rx_valid_o is high and rx_ready_i is low is discarded.
- R3: do_oe_o is high only while selected and not held, and do_o is high impedance whenever do_oe_o is low. A byte is loaded when chip select falls and again on the falling edge that follows each 8th rising edge. The byte comes from tx_data_i if tx_valid_i is high, and is 0xFF otherwise. Each other falling edge shifts the next bit out, MSB first.
- R4: Hold starts when chip select is low, the hold pin is low and the serial clock is low. If the hold pin falls while the clock is high, hold starts when the clock next goes low.
- R5: Hold ends when the hold pin is high and the serial clock is low. If the hold pin rises while the clock is high, hold ends when the clock next goes low.
- R6: During hold, clock edges and data-in are ignored, including the falling edge that ends the hold. The partial received byte and the outgoing bit position are kept, so the transfer resumes where it paused.
- R7: If chip select rises during hold, the serial logic is reset and the block locks out. It stays inactive, with do_oe_o low and no bytes captured, until both the hold pin and chip select are high. Only a new fall of chip select after that starts a transfer.
- R8: Chip select rising outside hold clears the bit counter and any partial byte.
- R9: The sector is req_addr_i[18:12], and address bits above bit 18 are ignored. With protect code bp_i = 0 no sector is protected, and with 7 all 128 sectors are protected. For codes 1 to 6, sectors 0 up to (128 - 2^bp_i) - 1 are protected.
- R10: A request that targets a protected sector is accepted at once (req_ready_o high) and is never shown on cmd_valid_o. prot_err_o pulses high in the cycle after the handshake.
- R11: An unprotected request appears on cmd_valid_o / cmd_addr_o in the same cycle, with req_ready_o equal to cmd_ready_i. While busy_i is high it is stalled (cmd_valid_o and req_ready_o low). The hold and chip-select state have no effect on this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin, idles low |
| csn_i | input | 1 | Chip select pin, active low |
| holdn_i | input | 1 | Hold pin, active low |
| di_i | input | 1 | Serial data-in pin |
| do_o | output | 1 | Serial data-out, high impedance when not driven |
| do_oe_o | output | 1 | Output enable for do_o |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Command layer accepts received byte |
| rx_data_o | output | 8 | Received byte |
| tx_valid_i | input | 1 | Byte to send is offered |
| tx_ready_o | output | 1 | Offered byte loaded into the shifter |
| tx_data_i | input | 8 | Byte to send |
| bp_i | input | 3 | Block-protect code from the status register |
| busy_i | input | 1 | Internal program/erase/status write in progress |
| req_valid_i | input | 1 | Program or erase request valid |
| req_ready_o | output | 1 | Request taken (forwarded or rejected) |
| req_addr_i | input | 24 | Request target address |
| cmd_valid_o | output | 1 | Forwarded request valid |
| cmd_ready_i | input | 1 | Command layer accepts request |
| cmd_addr_o | output | 24 | Forwarded request address |
| prot_err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
The assertions check four things on every cycle. Hold is entered and left only with the serial clock low, and lockout is left only with both pins high. The bit counter and partial byte do not move during hold, and a waiting received byte stays steady. The assertions also check that data-out is never enabled while deselected or locked out, and that busy always stalls forwarding. Other behaviour can only be shown by the bench's scenarios, because it needs whole pin sequences. That covers the deferral of entry and exit to the next low clock phase, and a transfer resuming with the correct bits after a pause. It also covers the lockout that outlives a reselect, and the exact sector boundary for each protect code.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_HOLD = 2'd1,
    HS_LOCK = 2'd2
  } hold_st_e;
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/sfl_hold_fsm.sv
module sfl_hold_fsm
  import sfl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_s,
  input  logic     csn_s,
  input  logic     holdn_s,
  output hold_st_e state_o
);
  hold_st_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      HS_RUN:  if (!csn_s && !holdn_s && !sck_s) nxt = HS_HOLD;
      HS_HOLD: if (csn_s) nxt = HS_LOCK;
               else if (holdn_s && !sck_s) nxt = HS_RUN;
      HS_LOCK: if (csn_s && holdn_s) nxt = HS_RUN;
      default: nxt = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= HS_RUN;
    else        st <= nxt;
  end

  assign state_o = st;

  // R4: hold begins only in a low clock phase while selected
  a_r4_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_HOLD && $past(st) == HS_RUN) |-> $past(!sck_s && !csn_s && !holdn_s));

  // R5: hold ends only in a low clock phase with the hold pin released
  a_r5_exit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_RUN && $past(st) == HS_HOLD) |-> $past(!sck_s && holdn_s));

  // R7: lockout is left only once both pins are high
  a_r7_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_RUN && $past(st) == HS_LOCK) |-> $past(csn_s && holdn_s));
endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_s,
  input  logic         csn_s,
  input  logic         di_s,
  input  logic         run_i,
  input  logic         tx_valid_i,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_ready_o,
  output logic         rx_valid_o,
  input  logic         rx_ready_i,
  output logic [W-1:0] rx_data_o,
  output logic         do_bit_o,
  output logic         do_oe_o
);
  localparam int CW = $clog2(W);

  logic          sck_q, csn_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  in_sh, out_sh;
  logic          rise, fall, active, start, load, done;

  assign rise   = sck_s & ~sck_q;
  assign fall   = ~sck_s & sck_q;
  assign active = run_i & ~csn_s;
  assign start  = run_i & ~csn_s & csn_q;
  assign load   = start | (active & fall & (cnt == '0));
  assign done   = active & rise & (cnt == CW'(W - 1));

  assign tx_ready_o = load & tx_valid_i;
  assign do_oe_o    = active;
  assign do_bit_o   = out_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      csn_q      <= 1'b1;
      cnt        <= '0;
      in_sh      <= '0;
      out_sh     <= '1;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
      if (csn_s) begin
        cnt   <= '0;
        in_sh <= '0;
      end else if (active && rise) begin
        in_sh <= {in_sh[W-2:0], di_s};
        cnt   <= (cnt == CW'(W - 1)) ? '0 : cnt + 1'b1;
      end
      if (load)                out_sh <= tx_valid_i ? tx_data_i : '1;
      else if (active && fall) out_sh <= {out_sh[W-2:0], 1'b1};
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
      if (done && (!rx_valid_o || rx_ready_i)) begin
        rx_valid_o <= 1'b1;
        rx_data_o  <= {in_sh[W-2:0], di_s};
      end
    end
  end

  // R6: bit state frozen while held or locked with chip select low
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !csn_s && !$past(run_i) && !$past(csn_s)) |-> ($stable(cnt) && $stable(in_sh)));

  // R2: a waiting byte is not disturbed
  a_r2_rx_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R3: output drive needs selection
  a_r3_oe_sel: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe_o |-> !csn_s);
endmodule

// File: rtl/sfl_prot_gate.sv
module sfl_prot_gate #(
  parameter int ADDR_W  = 24,
  parameter int SEC_LSB = 12,
  parameter int SEC_W   = 7,
  parameter int BP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BP_W-1:0]   bp_i,
  input  logic              busy_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              prot_err_o
);
  localparam int NBP  = 1 << BP_W;
  localparam int NSEC = 1 << SEC_W;

  function automatic logic sec_locked(logic [BP_W-1:0] b, logic [SEC_W-1:0] s);
    int span;
    if (b == '0) return 1'b0;
    if (b == '1) return 1'b1;
    span = 1 << (int'(b) + SEC_W + 1 - NBP);
    return int'(s) < (NSEC - span);
  endfunction

  logic hit;
  assign hit = sec_locked(bp_i, req_addr_i[SEC_LSB +: SEC_W]);

  assign cmd_valid_o = req_valid_i & ~hit & ~busy_i;
  assign req_ready_o = hit | (cmd_ready_i & ~busy_i);
  assign cmd_addr_o  = req_addr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_err_o <= 1'b0;
    else        prot_err_o <= req_valid_i & hit;
  end

  // R10: an error pulse follows a request taken without forwarding
  a_r10_err_src: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_o |-> $past(req_valid_i && req_ready_o && !cmd_valid_o));

  // R11: nothing is forwarded while busy
  a_r11_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !cmd_valid_o);
endmodule

// File: rtl/sfl_front.sv
module sfl_front
  import sfl_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SEC_LSB = 12,
  parameter int SEC_W   = 7,
  parameter int BP_W    = 3,
  parameter int W       = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              holdn_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [W-1:0]      rx_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [W-1:0]      tx_data_i,
  input  logic [BP_W-1:0]   bp_i,
  input  logic              busy_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              prot_err_o
);
  logic [3:0] pins_s;
  logic       sck_s, csn_s, holdn_s, di_s, do_bit;
  hold_st_e   hstate;

  sfl_sync #(.W(4), .RST_VAL(4'b0110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sck_i, csn_i, holdn_i, di_i}),
    .q_o(pins_s)
  );
  assign {sck_s, csn_s, holdn_s, di_s} = pins_s;

  sfl_hold_fsm u_hold (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .csn_s(csn_s), .holdn_s(holdn_s),
    .state_o(hstate)
  );

  sfl_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .csn_s(csn_s), .di_s(di_s),
    .run_i(hstate == HS_RUN),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o),
    .do_bit_o(do_bit), .do_oe_o(do_oe_o)
  );

  assign do_o = do_oe_o ? do_bit : 1'bz;

  sfl_prot_gate #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SEC_W(SEC_W), .BP_W(BP_W)) u_prot (
    .clk(clk), .rst_n(rst_n),
    .bp_i(bp_i), .busy_i(busy_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_addr_o(cmd_addr_o),
    .prot_err_o(prot_err_o)
  );

  // R7: locked-out slave never drives data-out
  a_r7_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hstate == HS_LOCK) |-> !do_oe_o);
endmodule

// File: tb/sim_sfl_front.sv
module sim_sfl_front;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, holdn = 1'b1, di = 1'b0;
  logic do_w, do_oe, rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
  logic [7:0]  rx_data, tx_data = 8'h00;
  logic [2:0]  bp = 3'd0;
  logic        busy = 1'b0, req_valid = 1'b0, req_ready, cmd_valid, cmd_ready = 1'b0, prot_err;
  logic [23:0] req_addr = '0, cmd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sfl_front u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .holdn_i(holdn), .di_i(di),
    .do_o(do_w), .do_oe_o(do_oe), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_data_o(rx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .bp_i(bp), .busy_i(busy), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .prot_err_o(prot_err)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one serial bit; optionally checks the data-out bit in the low phase
  task automatic sbit(input logic b, input bit chk_do, input logic exp_do, input string req);
    di = b;
    wclk(H);
    if (chk_do) chk1(req, do_w, exp_do);
    sck = 1'b1;
    wclk(H);
    sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] v, input bit chk_do, input logic [7:0] exp_do, input string req);
    for (int i = 7; i >= 0; i--) sbit(v[i], chk_do, exp_do[i], req);
    wclk(H);
  endtask

  task automatic accept();
    rx_ready = 1'b1;
    wclk(1);
    rx_ready = 1'b0;
  endtask

  task automatic idle();
    csn = 1'b1; holdn = 1'b1; sck = 1'b0; di = 1'b0;
    wclk(H);
  endtask

  task automatic t_reset();
    chk1("R3 reset oe", do_oe, 1'b0);
    chk1("R3 reset do z", do_w, 1'bz);
    chk1("R1 reset rx_valid", rx_valid, 1'b0);
    chk1("R10 reset prot_err", prot_err, 1'b0);
    chk1("R11 reset cmd_valid", cmd_valid, 1'b0);
  endtask

  task automatic t_basic();
    tx_valid = 1'b1; tx_data = 8'hA5;
    csn = 1'b0;
    wclk(H);
    tx_valid = 1'b0;
    chk1("R3 oe when selected", do_oe, 1'b1);
    sbyte(8'h3C, 1'b1, 8'hA5, "R3 do bits A5");
    chk1("R1 rx_valid", rx_valid, 1'b1);
    chk8("R1 rx_data", rx_data, 8'h3C);
    accept();
    sbyte(8'hC3, 1'b1, 8'hFF, "R3 fill FF");
    chk8("R1 second byte", rx_data, 8'hC3);
    accept();
    idle();
    chk1("R3 oe off deselected", do_oe, 1'b0);
  endtask

  task automatic t_backpressure();
    csn = 1'b0; wclk(H);
    sbyte(8'h11, 1'b0, 8'h00, "");
    sbyte(8'h22, 1'b0, 8'h00, "");
    chk1("R2 still valid", rx_valid, 1'b1);
    chk8("R2 first kept", rx_data, 8'h11);
    accept();
    chk1("R2 cleared on accept", rx_valid, 1'b0);
    idle();
  endtask

  task automatic t_cs_clear();
    csn = 1'b0; wclk(H);
    sbit(1'b1, 1'b0, 1'b0, ""); sbit(1'b1, 1'b0, 1'b0, ""); sbit(1'b1, 1'b0, 1'b0, "");
    wclk(H);
    csn = 1'b1; wclk(H);
    csn = 1'b0; wclk(H);
    sbyte(8'h81, 1'b0, 8'h00, "");
    chk8("R8 partial cleared", rx_data, 8'h81);
    accept();
    idle();
  endtask

  task automatic t_hold_low();
    logic [7:0] v = 8'h6B;
    logic [7:0] o = 8'h96;
    tx_valid = 1'b1; tx_data = o;
    csn = 1'b0; wclk(H);
    tx_valid = 1'b0;
    for (int i = 7; i >= 4; i--) sbit(v[i], 1'b1, o[i], "R3 pre-hold do");
    wclk(H);
    holdn = 1'b0; wclk(H);
    chk1("R4 hold oe off", do_oe, 1'b0);
    chk1("R4 hold do z", do_w, 1'bz);
    for (int k = 0; k < 3; k++) begin
      di = k[0]; sck = 1'b1; wclk(H); sck = 1'b0; wclk(H);
    end
    chk1("R6 clocks ignored oe", do_oe, 1'b0);
    holdn = 1'b1; wclk(H);
    chk1("R5 exit oe on", do_oe, 1'b1);
    chk1("R6 do resumes", do_w, o[3]);
    for (int i = 3; i >= 0; i--) sbit(v[i], 1'b1, o[i], "R6 post-hold do");
    wclk(H);
    chk8("R6 byte intact", rx_data, v);
    accept();
    idle();
  endtask

  task automatic t_hold_high();
    logic [7:0] v = 8'hC5;
    csn = 1'b0; wclk(H);
    sbit(v[7], 1'b0, 1'b0, ""); sbit(v[6], 1'b0, 1'b0, "");
    di = v[5]; wclk(H);
    sck = 1'b1; wclk(H);
    holdn = 1'b0; wclk(H);
    chk1("R4 entry deferred", do_oe, 1'b1);
    sck = 1'b0; wclk(H);
    chk1("R4 entry at low", do_oe, 1'b0);
    di = ~di;
    sck = 1'b1; wclk(H);
    holdn = 1'b1; wclk(H);
    chk1("R5 exit deferred", do_oe, 1'b0);
    sck = 1'b0; wclk(H);
    chk1("R5 exit at low", do_oe, 1'b1);
    for (int i = 4; i >= 0; i--) sbit(v[i], 1'b0, 1'b0, "");
    wclk(H);
    chk8("R6 edges in hold ignored", rx_data, v);
    accept();
    idle();
  endtask

  task automatic t_lockout();
    csn = 1'b0; wclk(H);
    for (int i = 0; i < 4; i++) sbit(1'b1, 1'b0, 1'b0, "");
    wclk(H);
    holdn = 1'b0; wclk(H);
    csn = 1'b1; wclk(H);
    csn = 1'b0; wclk(H);
    chk1("R7 locked after reselect", do_oe, 1'b0);
    sbyte(8'hFF, 1'b0, 8'h00, "");
    chk1("R7 no capture locked", rx_valid, 1'b0);
    holdn = 1'b1; wclk(H);
    chk1("R7 still locked cs low", do_oe, 1'b0);
    csn = 1'b1; wclk(H);
    csn = 1'b0; wclk(H);
    chk1("R7 resumed", do_oe, 1'b1);
    sbyte(8'h5E, 1'b0, 8'h00, "");
    chk8("R7 fresh byte", rx_data, 8'h5E);
    accept();
    idle();
  endtask

  function automatic int lim_of(input int b);
    if (b == 0) return 0;
    if (b == 7) return 128;
    return 128 - (1 << b);
  endfunction

  task automatic req1(input logic [23:0] a, input logic exp_hit, input string req);
    req_valid = 1'b1; req_addr = a;
    #1;
    chk1({req, " cmd_valid"}, cmd_valid, ~exp_hit);
    chk1({req, " req_ready"}, req_ready, 1'b1);
    if (!exp_hit) chk8({req, " cmd_addr"}, cmd_addr[19:12], a[19:12]);
    wclk(1);
    req_valid = 1'b0;
    chk1({req, " prot_err"}, prot_err, exp_hit);
    wclk(1);
  endtask

  task automatic t_protect();
    cmd_ready = 1'b1; busy = 1'b0;
    for (int b = 0; b < 8; b++) begin
      int lim = lim_of(b);
      bp = 3'(b);
      if (lim > 0)   req1({5'h1F, 7'(lim - 1), 12'hABC}, 1'b1, "R9 R10 last locked");
      if (lim < 128) req1({5'h15, 7'(lim), 12'h123}, 1'b0, "R9 R11 first free");
    end
  endtask

  task automatic t_busy();
    bp = 3'd0; cmd_ready = 1'b1; busy = 1'b1;
    req_valid = 1'b1; req_addr = 24'h012345;
    #1;
    chk1("R11 busy stalls valid", cmd_valid, 1'b0);
    chk1("R11 busy stalls ready", req_ready, 1'b0);
    wclk(1);
    busy = 1'b0; cmd_ready = 1'b0;
    #1;
    chk1("R11 valid w/o ready", cmd_valid, 1'b1);
    chk1("R11 ready follows cmd", req_ready, 1'b0);
    wclk(1);
    req_valid = 1'b0; cmd_ready = 1'b1;
    csn = 1'b0; holdn = 1'b0; wclk(H);
    chk1("R4 in hold for R11", do_oe, 1'b0);
    req1(24'h070000, 1'b0, "R11 forwarded during hold");
    bp = 3'd7;
    req1(24'h000000, 1'b1, "R10 rejected during hold");
    bp = 3'd0;
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wclk(H);
    t_reset();
    t_basic();
    t_backpressure();
    t_cs_clear();
    t_hold_low();
    t_hold_high();
    t_lockout();
    t_protect();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule